// File: doc/BRIEF.md
# Serial Byte Transmitter with Break Generation

This block serialises bytes onto an asynchronous line using start, eight data bits (least significant first) and one stop bit. A one-byte holding register sits in front of the shift register. Software can write the next byte while the current frame is still being shifted out. Bit timing comes from an external strobe: every bit lasts a fixed number of these strobes, 16 by default.

For bus protocols that open a message with a long dominant period, the block can also send a break. A break is a frame that starts low, stays low for twelve further bit times and ends with a high stop bit. Software arms it with a set pulse while the transmitter is enabled. The next byte written triggers the break, and the value of that byte is thrown away. The break flag clears itself when the break's stop bit has gone out. A byte placed in the holding register during the break, usually a 0x55 sync pattern, is therefore sent as an ordinary frame immediately afterwards.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset, txd is high, buf_empty is 1, shf_idle is 1 and brk_bit is 0.
- R2: A normal frame on txd is one low start bit, then the 8 data bits starting with bit 0, then one high stop bit. Each bit lasts exactly 16 baud_tick strobes, and txd is high between frames.
- R3: A write accepted into an empty holding register drops buf_empty on the next clock edge. If the shifter is idle, the byte moves into the shifter one edge later: at that edge buf_empty returns to 1 and shf_idle goes to 0.
- R4: A write while the holding register is full is ignored. buf_empty stays 0, and the ignored byte never appears on txd.
- R5: With brk_bit set, the next byte that moves into the shifter produces a break frame instead of a normal frame. A break frame is a low start bit, 12 low bits and a high stop bit, 14 bit times in all. The written value is discarded.
- R6: brk_bit stays 1 through the whole break frame, including its stop bit. It returns to 0 on the clock edge at which the break's stop bit ends. A brk_set pulse sets it.
- R7: A byte written while a break is being sent goes out as a normal frame. Its start bit begins one clock cycle after the break's stop bit ends.
- R8: shf_idle is 0 for the whole duration of every frame, whether normal or break.
- R9: When tx_en is low, the frame in progress is abandoned and txd returns high on the next edge. The holding register is emptied, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit time |
| tx_en | input | 1 | Transmitter enable; low aborts and flushes |
| brk_set | input | 1 | Pulse that arms a break for the next loaded byte |
| wr_en | input | 1 | Byte write strobe into the holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output line, idle high |
| buf_empty | output | 1 | Holding register can accept a byte |
| shf_idle | output | 1 | Shift register holds no frame |
| brk_bit | output | 1 | Break request flag, cleared by hardware |

## Verification
The hardest case is the break-to-sync hand-off. The sync byte must already be waiting when the break's stop bit finishes, and the flag must clear in time for that byte to be loaded as a normal frame. The stimulus writes the dummy byte and then the 0x55 byte a few cycles apart, while the break is still shifting. A free-running frame monitor in the bench measures the idle gap between the two frames and records brk_bit both during the break's stop bit and in the gap cycle. A similar overlap is used for the ignored third write: two bytes are queued back to back so the holding register is full when the extra write arrives.

// File: rtl/brk_uart_tx_pkg.sv
package brk_uart_tx_pkg;

    localparam int UTX_DATA_W    = 8;
    localparam int UTX_OSR       = 16;
    localparam int UTX_BRK_ZEROS = 12;

    typedef enum logic {
        FRM_NORMAL = 1'b0,
        FRM_BREAK  = 1'b1
    } frm_kind_e;

    function automatic int unsigned frm_len(frm_kind_e kind, int unsigned data_w,
                                            int unsigned brk_zeros);
        return (kind == FRM_BREAK) ? brk_zeros + 2 : data_w + 2;
    endfunction

    function automatic int unsigned shift_width(int unsigned data_w, int unsigned brk_zeros);
        return ((brk_zeros > data_w) ? brk_zeros : data_w) + 2;
    endfunction

endpackage

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
    parameter int DATA_W = brk_uart_tx_pkg::UTX_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    // a write into a full register leaves its content untouched
    p_full_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !take && tx_en) |=> (full && $stable(data)));

    // the shifter only takes a byte that is actually there
    p_take_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
        take |-> full);

endmodule

// File: rtl/utx_bit_timer.sv
module utx_bit_timer #(
    parameter int OSR = brk_uart_tx_pkg::UTX_OSR
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic baud_tick,
    output logic bit_done
);

    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = run && baud_tick && (cnt == LAST);

    // the oversampling count only moves on a strobe
    p_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !baud_tick) |=> ((cnt == $past(cnt)) || !run));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import brk_uart_tx_pkg::*;
#(
    parameter int DATA_W    = UTX_DATA_W,
    parameter int BRK_ZEROS = UTX_BRK_ZEROS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              load,
    input  frm_kind_e         load_kind,
    input  logic [DATA_W-1:0] load_data,
    input  logic              bit_done,
    output logic              txd,
    output logic              busy,
    output frm_kind_e         kind,
    output logic              frame_end
);

    localparam int SH_W  = shift_width(DATA_W, BRK_ZEROS);
    localparam int CNT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] LEN_NORM = CNT_W'(frm_len(FRM_NORMAL, DATA_W, BRK_ZEROS));
    localparam logic [CNT_W-1:0] LEN_BRK  = CNT_W'(frm_len(FRM_BREAK, DATA_W, BRK_ZEROS));

    logic [SH_W-1:0]  sreg;
    logic [CNT_W-1:0] left;
    logic [SH_W-1:0]  frame_norm;
    logic [SH_W-1:0]  frame_brk;

    always_comb begin
        frame_norm = {{(SH_W - DATA_W - 1){1'b1}}, load_data, 1'b0};
        frame_brk  = {{(SH_W - BRK_ZEROS - 1){1'b1}}, {(BRK_ZEROS + 1){1'b0}}};
    end

    assign frame_end = busy && bit_done && (left == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            left <= '0;
            sreg <= '1;
            kind <= FRM_NORMAL;
        end else if (load) begin
            busy <= 1'b1;
            kind <= load_kind;
            if (load_kind == FRM_BREAK) begin
                sreg <= frame_brk;
                left <= LEN_BRK;
            end else begin
                sreg <= frame_norm;
                left <= LEN_NORM;
            end
        end else if (busy && bit_done) begin
            sreg <= {1'b1, sreg[SH_W-1:1]};
            left <= left - 1'b1;
            if (left == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign txd = busy ? sreg[0] : 1'b1;

    // a frame in flight always has bits left to send
    p_left_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left != '0));

    // a new frame never overwrites one in flight
    p_load_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
    import brk_uart_tx_pkg::*;
#(
    parameter int DATA_W    = UTX_DATA_W,
    parameter int OSR       = UTX_OSR,
    parameter int BRK_ZEROS = UTX_BRK_ZEROS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk_set,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              buf_empty,
    output logic              shf_idle,
    output logic              brk_bit
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              busy;
    logic              load;
    logic              bit_done;
    logic              frame_end;
    frm_kind_e         cur_kind;
    frm_kind_e         next_kind;
    logic              brk_flag;

    assign load      = tx_en && hold_full && !busy;
    assign next_kind = brk_flag ? FRM_BREAK : FRM_NORMAL;

    utx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    utx_bit_timer #(.OSR(OSR)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    utx_shifter #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .abort     (!tx_en),
        .load      (load),
        .load_kind (next_kind),
        .load_data (hold_data),
        .bit_done  (bit_done),
        .txd       (txd),
        .busy      (busy),
        .kind      (cur_kind),
        .frame_end (frame_end)
    );

    // break flag: set by request, cleared when a break frame's stop bit ends
    always_ff @(posedge clk) begin
        if (rst) begin
            brk_flag <= 1'b0;
        end else begin
            if (frame_end && cur_kind == FRM_BREAK) begin
                brk_flag <= 1'b0;
            end
            if (brk_set) begin
                brk_flag <= 1'b1;
            end
        end
    end

    assign buf_empty = !hold_full;
    assign shf_idle  = !busy;
    assign brk_bit   = brk_flag;

    // disabling empties everything on the next edge
    p_abort_flush_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (shf_idle && buf_empty));

    // the flag only drops together with the end of a frame
    p_brk_clear_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_flag) |-> shf_idle);

    // a hand-over starts a frame and frees the holding register
    p_handover_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> (!shf_idle && buf_empty));

endmodule

// File: tb/brk_uart_tx_bench.sv
module brk_uart_tx_bench;

    localparam int TICK_DIV = 3;
    localparam int BIT_CYC  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick;
    logic       tx_en;
    logic       brk_set;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       txd;
    logic       buf_empty;
    logic       shf_idle;
    logic       brk_bit;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct packed {
        logic [13:0] bits;
        logic [4:0]  n;
        logic [15:0] gap;
        logic        brk_mid;
        logic        brk_after;
    } rec_t;

    rec_t recs[$];

    always #10 clk = ~clk;

    brk_uart_tx u_brk_uart_tx (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .brk_set   (brk_set),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .txd       (txd),
        .buf_empty (buf_empty),
        .shf_idle  (shf_idle),
        .brk_bit   (brk_bit)
    );

    // free-running strobe, one cycle in TICK_DIV
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == TICK_DIV - 1);
    end

    // frame monitor: samples each bit in its middle
    logic        m_in   = 1'b0;
    int          m_cyc  = 0;
    int          m_n    = 0;
    int          m_gap  = 0;
    logic [13:0] m_bits = '0;
    logic        m_brk  = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!shf_idle) begin
                if (!m_in) begin
                    m_in   = 1'b1;
                    m_cyc  = 0;
                    m_n    = 0;
                    m_bits = '0;
                end
                m_cyc = m_cyc + 1;
                if (m_n < 14 && m_cyc == 25 + BIT_CYC * m_n) begin
                    m_bits[m_n] = txd;
                    m_brk       = brk_bit;
                    m_n         = m_n + 1;
                end
            end else begin
                if (m_in) begin
                    recs.push_back('{bits: m_bits, n: 5'(m_n), gap: 16'(m_gap),
                                     brk_mid: m_brk, brk_after: brk_bit});
                    m_in  = 1'b0;
                    m_gap = 1;
                end else if (m_gap < 60000) begin
                    m_gap = m_gap + 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] exp_bits(input logic brk, input logic [7:0] d);
        if (brk) return 14'b10_0000_0000_0000;
        return {4'b0000, 1'b1, d, 1'b0};
    endfunction

    function automatic int exp_len(input logic brk);
        return brk ? 14 : 10;
    endfunction

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_recs(input int k);
        while (recs.size() < k) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input rec_t r, input logic brk,
                               input logic [7:0] d);
        logic [13:0] mask;
        mask = (exp_len(brk) == 14) ? 14'h3fff : 14'h03ff;
        check(req, int'(r.n), exp_len(brk));
        check(req, int'(r.bits & mask), int'(exp_bits(brk, d)));
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rec_t r;
        logic [7:0] a, b, c;
        int unsigned seed;
        seed      = $urandom(32'd20240);
        rst       = 1'b1;
        tx_en     = 1'b0;
        brk_set   = 1'b0;
        wr_en     = 1'b0;
        wr_data   = '0;
        baud_tick = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 txd", txd, 1);
        check("R1 buf_empty", buf_empty, 1);
        check("R1 shf_idle", shf_idle, 1);
        check("R1 brk_bit", brk_bit, 0);

        tx_en = 1'b1;
        @(negedge clk);

        // R3 hand-over timing for a write into an idle transmitter
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 full after write", buf_empty, 0);
        check("R3 idle before load", shf_idle, 1);
        @(negedge clk);
        check("R3 empty after load", buf_empty, 1);
        check("R8 busy after load", shf_idle, 0);
        check("R2 start bit low", txd, 0);
        wait_recs(1);
        r = recs.pop_front();
        check_frame("R2 directed C3", r, 1'b0, 8'hC3);
        check("R2 line high between frames", txd, 1);

        // R2 random single frames
        for (int i = 0; i < 6; i++) begin
            a = 8'($urandom);
            do_write(a);
            wait_recs(1);
            r = recs.pop_front();
            check_frame("R2 random frame", r, 1'b0, a);
        end

        // R4 two queued bytes then an ignored third write
        a = 8'($urandom); b = 8'($urandom); c = ~b;
        do_write(a);
        do_write(b);
        do_write(c);
        check("R4 still full after ignored write", buf_empty, 0);
        wait_recs(2);
        r = recs.pop_front();
        check_frame("R4 first", r, 1'b0, a);
        r = recs.pop_front();
        check_frame("R4 second kept", r, 1'b0, b);
        repeat (BIT_CYC * 12) @(negedge clk);
        check("R4 no third frame", recs.size(), 0);
        check("R4 idle after", shf_idle, 1);

        // R5 R6 R7 break followed by sync
        @(negedge clk);
        brk_set = 1'b1;
        @(negedge clk);
        brk_set = 1'b0;
        check("R6 flag set", brk_bit, 1);
        do_write(8'hA7);
        repeat (20) @(negedge clk);
        check("R8 busy during break", shf_idle, 0);
        do_write(8'h55);
        wait_recs(2);
        r = recs.pop_front();
        check_frame("R5 break frame", r, 1'b1, 8'h00);
        check("R6 flag held at stop bit", r.brk_mid, 1);
        check("R6 flag cleared at end", r.brk_after, 0);
        r = recs.pop_front();
        check_frame("R7 sync after break", r, 1'b0, 8'h55);
        check("R7 one cycle gap", int'(r.gap), 1);
        check("R6 flag stays clear", brk_bit, 0);

        // R9 abort in the middle of a frame
        do_write(8'h0F);
        do_write(8'hF0);
        repeat (BIT_CYC * 3) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check("R9 txd high", txd, 1);
        check("R9 idle", shf_idle, 1);
        check("R9 buffer flushed", buf_empty, 1);
        do_write(8'h12);
        check("R9 write ignored", buf_empty, 1);
        tx_en = 1'b1;
        recs.delete();
        repeat (BIT_CYC * 12) @(negedge clk);
        check("R9 nothing sent after re-enable", recs.size(), 0);
        check("R9 line idle", txd, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule